// File: doc/BRIEF.md
# Reloading Interval Timer

This block is a per-processor interval timer on a simple valid/write/address/data register bus. Software writes a reload value into a divider register. A load command copies that value into a down-counter without starting it, and a separate run command starts the count. When the count runs out, the counter reloads itself from the divider and raises a pending event. The count can be read back at any time, so the time elapsed within the current period is the divider minus the count, multiplied by the tick period.

The pending event is visible only through a masked status register and the interrupt output. It stays set until software writes a one to the acknowledge register. A clock-select field picks the tick source: every clock, or a slower strobe from an internal prescaler. Beside the timer sits a free-running read-only time counter that advances on every clock. A typical setup writes a divider of 1,000,000 at a 100 MHz tick, which gives one event every 10 ms.

Top module: `ivtimer`

## Requirements
- R1: After reset the divider, count, mask, pending flag, status and irq_o all read 0, and the timer is stopped.
- R2: Word address 1 is the control register. Bits [1:0] select the operation: 0 stop, 1 load, 2 run, 3 keep the run state. A load command copies the divider (address 0) into the count (address 2) and leaves the count frozen.
- R3: While running at select 0 (control bits [3:2]), the count drops by exactly one on every clock after the run command's edge.
- R4: On a tick with a count of 1 (or 0), the count is set to the divider in the same edge and the pending flag is set. The period is therefore divider ticks.
- R5: The status register (address 4, bit 0) and irq_o equal the pending flag ANDed with mask bit 0 (address 3). A masked event stays pending and appears once the mask is set.
- R6: Writing 1 to bit 0 of the acknowledge register (address 5) clears the pending flag. Writing 0 there has no effect.
- R7: If an event and an acknowledge fall in the same cycle, the pending flag stays set.
- R8: A divider write while running does not disturb the current count. The new value is used at the next reload.
- R9: After a stop command the count holds its value.
- R10: Select 1 steps the count once every PRE_DIV clocks. Selects 2 and 3 hold the count.
- R11: The time register (address 6) increments by one on every clock, modulo 2^DW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Bus access strobe |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, combinational from bus_addr |
| irq_o | output | 1 | Masked pending event |

## Verification
The bound checker examines the following on every cycle:
- Each plain tick lowers the count by one.
- Each reload takes the divider value as it stood before the edge.
- The count holds whenever there is neither a tick nor a load.
- The interrupt equals pending AND mask.
- An acknowledge clears the flag unless an event coincides with it.
- The time counter steps by one, including across its wrap.

Only the bench scenarios can show the behaviour seen from the bus:
- The exact period and the cycle in which the event appears.
- A divider rewrite that waits for the next reload.
- The prescaled rate under select 1.
- Masked events surfacing when the mask is set later.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
  localparam int AW = 3;

  typedef enum logic [1:0] {
    OP_STOP = 2'd0,
    OP_LOAD = 2'd1,
    OP_RUN  = 2'd2,
    OP_KEEP = 2'd3
  } ivt_op_e;

  typedef enum logic [1:0] {
    SEL_FULL = 2'd0,
    SEL_SLOW = 2'd1,
    SEL_RSV2 = 2'd2,
    SEL_RSV3 = 2'd3
  } ivt_sel_e;

  localparam logic [AW-1:0] A_DIV    = 3'd0;
  localparam logic [AW-1:0] A_CTRL   = 3'd1;
  localparam logic [AW-1:0] A_COUNT  = 3'd2;
  localparam logic [AW-1:0] A_MASK   = 3'd3;
  localparam logic [AW-1:0] A_STATUS = 3'd4;
  localparam logic [AW-1:0] A_ACK    = 3'd5;
  localparam logic [AW-1:0] A_TIME   = 3'd6;
endpackage

// File: rtl/ivt_regs.sv
module ivt_regs
  import ivt_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_valid,
  input  logic          bus_write,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] divider_q,
  output logic          mask_q,
  output ivt_sel_e      sel_q,
  output logic          load_hit,
  output logic          run_hit,
  output logic          stop_hit,
  output logic          ack_hit
);
  logic    wr_en;
  logic    ctrl_wr;
  ivt_op_e op_w;

  assign wr_en    = bus_valid && bus_write;
  assign ctrl_wr  = wr_en && (bus_addr == A_CTRL);
  assign op_w     = ivt_op_e'(bus_wdata[1:0]);
  assign load_hit = ctrl_wr && (op_w == OP_LOAD);
  assign run_hit  = ctrl_wr && (op_w == OP_RUN);
  assign stop_hit = ctrl_wr && (op_w == OP_STOP);
  assign ack_hit  = wr_en && (bus_addr == A_ACK) && bus_wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      divider_q <= '0;
      mask_q    <= 1'b0;
      sel_q     <= SEL_FULL;
    end else begin
      if (wr_en && bus_addr == A_DIV)  divider_q <= bus_wdata;
      if (wr_en && bus_addr == A_MASK) mask_q    <= bus_wdata[0];
      if (ctrl_wr)                     sel_q     <= ivt_sel_e'(bus_wdata[3:2]);
    end
  end
endmodule

// File: rtl/ivt_down.sv
module ivt_down
  import ivt_pkg::*;
#(
  parameter int DW      = 32,
  parameter int PRE_DIV = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] divider,
  input  ivt_sel_e      sel,
  input  logic          load_hit,
  input  logic          run_hit,
  input  logic          stop_hit,
  input  logic          ack_hit,
  output logic [DW-1:0] count,
  output logic          running,
  output logic          tick,
  output logic          reload_ev,
  output logic          raw_pend
);
  localparam int PW = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;

  logic slow_stb;

  function automatic logic [DW-1:0] step_count(input logic [DW-1:0] cur,
                                               input logic [DW-1:0] rld);
    return (cur <= DW'(1)) ? rld : cur - DW'(1);
  endfunction

  generate
    if (PRE_DIV > 1) begin : g_pre
      logic [PW-1:0] pre_cnt;
      always_ff @(posedge clk) begin
        if (!rst_n)                          pre_cnt <= '0;
        else if (pre_cnt == PW'(PRE_DIV - 1)) pre_cnt <= '0;
        else                                  pre_cnt <= pre_cnt + PW'(1);
      end
      assign slow_stb = (pre_cnt == PW'(PRE_DIV - 1));
    end else begin : g_nopre
      assign slow_stb = 1'b1;
    end
  endgenerate

  always_comb begin
    unique case (sel)
      SEL_FULL: tick = running;
      SEL_SLOW: tick = running && slow_stb;
      default:  tick = 1'b0;
    endcase
  end

  assign reload_ev = tick && !load_hit && (count <= DW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count    <= '0;
      running  <= 1'b0;
      raw_pend <= 1'b0;
    end else begin
      if (load_hit)  count <= divider;
      else if (tick) count <= step_count(count, divider);
      if (load_hit || stop_hit) running <= 1'b0;
      else if (run_hit)         running <= 1'b1;
      raw_pend <= reload_ev || (raw_pend && !ack_hit);
    end
  end
endmodule

// File: rtl/ivt_freerun.sv
module ivt_freerun #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [DW-1:0] time_cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n) time_cnt <= '0;
    else        time_cnt <= time_cnt + DW'(1);
  end
endmodule

// File: rtl/ivtimer.sv
module ivtimer
  import ivt_pkg::*;
#(
  parameter int DW      = 32,
  parameter int PRE_DIV = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_valid,
  input  logic          bus_write,
  input  logic [2:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq_o
);
  logic [DW-1:0] divider_q;
  logic          mask_q;
  ivt_sel_e      sel_q;
  logic          load_hit, run_hit, stop_hit, ack_hit;
  logic [DW-1:0] count;
  logic          running, tick, reload_ev, raw_pend;
  logic [DW-1:0] time_cnt;

  ivt_regs #(.DW(DW)) regs_i (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .divider_q(divider_q),
    .mask_q(mask_q), .sel_q(sel_q), .load_hit(load_hit), .run_hit(run_hit),
    .stop_hit(stop_hit), .ack_hit(ack_hit)
  );

  ivt_down #(.DW(DW), .PRE_DIV(PRE_DIV)) down_i (
    .clk(clk), .rst_n(rst_n), .divider(divider_q), .sel(sel_q),
    .load_hit(load_hit), .run_hit(run_hit), .stop_hit(stop_hit),
    .ack_hit(ack_hit), .count(count), .running(running), .tick(tick),
    .reload_ev(reload_ev), .raw_pend(raw_pend)
  );

  ivt_freerun #(.DW(DW)) free_i (
    .clk(clk), .rst_n(rst_n), .time_cnt(time_cnt)
  );

  assign irq_o = raw_pend && mask_q;

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      A_DIV:    bus_rdata = divider_q;
      A_CTRL:   bus_rdata = {{(DW-4){1'b0}}, sel_q, 1'b0, running};
      A_COUNT:  bus_rdata = count;
      A_MASK:   bus_rdata = {{(DW-1){1'b0}}, mask_q};
      A_STATUS: bus_rdata = {{(DW-1){1'b0}}, irq_o};
      A_TIME:   bus_rdata = time_cnt;
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/ivtimer_chk.sv
module ivtimer_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [DW-1:0] count,
  input logic [DW-1:0] divider,
  input logic          tick,
  input logic          load_hit,
  input logic          reload_ev,
  input logic          ack_hit,
  input logic          raw_pend,
  input logic          mask_q,
  input logic          irq_o,
  input logic [DW-1:0] time_cnt
);
  logic past_ok;
  always_ff @(posedge clk) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // R3
  step_down_chk: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    (tick && !load_hit && count > DW'(1)) |=> (count == $past(count) - DW'(1)));

  // R4
  reload_val_chk: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    reload_ev |=> (count == $past(divider) && raw_pend));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    (!tick && !load_hit) |=> $stable(count));

  // R5
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (raw_pend && mask_q));

  // R6
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    (ack_hit && !reload_ev) |=> !raw_pend);

  // R7
  ack_race_chk: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    (ack_hit && reload_ev) |=> raw_pend);

  // R11
  time_step_chk: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    (time_cnt - $past(time_cnt)) == DW'(1));
endmodule

bind ivtimer ivtimer_chk #(.DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .count(count), .divider(divider_q), .tick(tick),
  .load_hit(load_hit), .reload_ev(reload_ev), .ack_hit(ack_hit),
  .raw_pend(raw_pend), .mask_q(mask_q), .irq_o(irq_o), .time_cnt(time_cnt)
);

// File: tb/ivtimer_tb_top.sv
module ivtimer_tb_top;
  localparam int DW = 32;
  localparam int PRE = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_valid = 1'b0;
  logic          bus_write = 1'b0;
  logic [2:0]    bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          irq_o;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  ivtimer #(.DW(DW), .PRE_DIV(PRE)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Called just after a falling edge; consumes one rising edge.
  task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [DW-1:0] d);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_valid = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [DW-1:0] v;
    rd(3'd0, v); check("R1 divider", v, 0);
    rd(3'd2, v); check("R1 count", v, 0);
    rd(3'd3, v); check("R1 mask", v, 0);
    rd(3'd4, v); check("R1 status", v, 0);
    rd(3'd1, v); check("R1 stopped", v, 0);
    check("R1 irq", {31'd0, irq_o}, 0);
  endtask

  task automatic t_period;
    logic [DW-1:0] v;
    wr(3'd0, 5);
    wr(3'd1, 1);
    rd(3'd2, v); check("R2 load copies divider", v, 5);
    wait_cyc(4);
    rd(3'd2, v); check("R2 frozen after load", v, 5);
    wr(3'd3, 1);
    wr(3'd1, 2);
    rd(3'd2, v); check("R3 count at run edge", v, 5);
    wait_cyc(1);
    rd(3'd2, v); check("R3 one step", v, 4);
    wait_cyc(3);
    rd(3'd2, v); check("R4 count before reload", v, 1);
    check("R4 no irq yet", {31'd0, irq_o}, 0);
    wait_cyc(1);
    rd(3'd2, v); check("R4 reload value", v, 5);
    rd(3'd4, v); check("R4 status set", v, 1);
    check("R5 irq follows", {31'd0, irq_o}, 1);
    wait_cyc(4);
    wr(3'd5, 1);
    rd(3'd4, v); check("R7 event beats ack", v, 1);
    rd(3'd2, v); check("R7 reload with ack", v, 5);
    wr(3'd5, 0);
    rd(3'd4, v); check("R6 ack zero ignored", v, 1);
    wr(3'd5, 1);
    rd(3'd4, v); check("R6 ack clears", v, 0);
    wr(3'd1, 0);
    rd(3'd2, v); check("R9 count at stop", v, 2);
    wait_cyc(10);
    rd(3'd2, v); check("R9 count held", v, 2);
  endtask

  task automatic t_mask;
    logic [DW-1:0] v;
    wr(3'd3, 0);
    wr(3'd1, 2);
    wait_cyc(2);
    rd(3'd4, v); check("R5 masked status", v, 0);
    check("R5 masked irq", {31'd0, irq_o}, 0);
    wr(3'd1, 0);
    wr(3'd3, 1);
    rd(3'd4, v); check("R5 unmask shows pending", v, 1);
    check("R5 irq after unmask", {31'd0, irq_o}, 1);
    wr(3'd5, 1);
    check("R6 irq cleared", {31'd0, irq_o}, 0);
  endtask

  task automatic t_divchg;
    logic [DW-1:0] v;
    wr(3'd0, 20);
    wr(3'd1, 1);
    wr(3'd1, 2);
    wr(3'd0, 6);
    rd(3'd2, v); check("R8 count undisturbed", v, 19);
    rd(3'd0, v); check("R8 divider updated", v, 6);
    wait_cyc(18);
    rd(3'd2, v); check("R8 old period runs out", v, 1);
    wait_cyc(1);
    rd(3'd2, v); check("R8 new divider at reload", v, 6);
    wr(3'd1, 0);
    wr(3'd5, 1);
  endtask

  task automatic t_slow;
    logic [DW-1:0] a, b;
    wr(3'd0, 1000);
    wr(3'd1, 1);
    wr(3'd1, 2 | (1 << 2));
    rd(3'd2, a);
    wait_cyc(PRE * 4);
    rd(3'd2, b);
    check("R10 slow rate steps", a - b, 4);
    wr(3'd1, 3 | (2 << 2));
    rd(3'd2, a);
    wait_cyc(20);
    rd(3'd2, b);
    check("R10 select 2 holds", b, a);
    wr(3'd1, 3 | (3 << 2));
    rd(3'd2, a);
    wait_cyc(20);
    rd(3'd2, b);
    check("R10 select 3 holds", b, a);
    wr(3'd1, 0);
  endtask

  task automatic t_time;
    logic [DW-1:0] a, b;
    rd(3'd6, a);
    wait_cyc(37);
    rd(3'd6, b);
    check("R11 time advances per clock", b - a, 37);
  endtask

  task automatic finish_up;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_up();
  end

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(1);
    t_reset();
    t_period();
    t_mask();
    t_divchg();
    t_slow();
    t_time();
    finish_up();
  end
endmodule